// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Masked Writes and Pin Interrupts

The block is a bank of general-purpose pins behind a 32-bit word-addressed register port. Every writable register is written with a per-pin enable mask in the upper half-word and new pin values in the lower half-word. Software can therefore set or clear a single pin's direction, output, trigger setup or pending flag in one store, with no read-modify-write. Each pin can be handed to an alternate on-chip peripheral through an ownership bit. When it is handed over, that peripheral drives the pin's output level and output enable.

Pin inputs pass through a two-stage synchroniser. The synchronised level feeds a readable input register and a per-pin trigger detector. The detector works in edge mode (rising or falling) or in level mode (high or low). Pending flags are sticky, and software clears them one pin at a time. A single interrupt request combines every pin whose flag is pending, whose interrupt enable is set and whose GPIO direction is input.

The pin count is a parameter (at most 16). A reduced bank reads zero in the unused pin positions and ignores writes to them.

Top module: `gpio_bank`

## Requirements
- R1: On a write to a writable register, bit 16+i of the write data enables pin i and bit i carries its new value. Pins whose enable bit is 0 keep their previous value. When master select is 1, `pin_out` and `pin_oe` follow the output-data and direction registers.
- R2: While reset is held, reads return the following values. Direction (0x00), output (0x04), input (0x08), polarity (0x0C), type (0x10), enable (0x14), status (0x18) and pull-up (0x20) all read 0. Master select (0x1C) reads all ones. `pin_oe` and `irq` are 0.
- R3: The input register (0x08) returns each pin's level two clocks after it changes on `pin_in`, whatever the pin's direction. One clock after the change it still shows the old level.
- R4: When type bit = 1 (edge), polarity 1 selects rising and polarity 0 selects falling. A matching edge sets the status bit on the third clock after the pin change, and the opposite edge does not set it.
- R5: When type bit = 0 (level), the status bit is set on every clock while the pin sits at its active level (polarity 1 = high, 0 = low). A clear has no effect while that level holds. The bit stays set after the level goes away, until it is cleared.
- R6: A status write clears exactly the pins whose mask bit is 1 and whose data bit is 0. Data bit 1 sets nothing, and unmasked pending bits remain set.
- R7: If a trigger event and a clear write hit the same status bit in the same clock, the bit ends up set.
- R8: `irq` is 1 exactly when some pin has its status bit, its enable bit and a 0 in the direction register all at once.
- R9: A pin whose master-select bit is 0 takes `pin_out` and `pin_oe` from `alt_out` and `alt_oe`. Other pins are not affected.
- R10: Writes to the input register and to offsets above 0x20 change nothing. Reads of offsets above 0x20 return 0, and bits 31:16 of every read are 0.
- R11: The pull-up register (0x20) appears on `pin_pullup` and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 6 | Byte address; bits 5:2 select the register |
| bus_wdata | input | 32 | Mask in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | PINS | Raw pin levels |
| pin_out | output | PINS | Output level to pads |
| pin_oe | output | PINS | Output enable to pads |
| pin_pullup | output | PINS | Pull-up enable to pads |
| alt_out | input | PINS | Alternate-function output level |
| alt_oe | input | PINS | Alternate-function output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench lines up a clear write with the clock in which an edge event lands. A design in which the clear wins would lose that interrupt for good. It holds a pin at its active level while it clears the pin in level mode, and again after the level has gone. A design that is not level-sensitive would drop the flag early, and a design that is not sticky would drop it late. Masked status writes with data 1 and with other bits pending catch a design that treats the register as plain data or clears the whole word. The interrupt line is toggled by turning a pending pin into an output and back, which exposes a design that leaves out the direction term.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int MAX_PINS = 16;
    localparam int ADDR_W   = 6;

    typedef enum logic [3:0] {
        REG_DIR   = 4'd0,
        REG_DOUT  = 4'd1,
        REG_DIN   = 4'd2,
        REG_POL   = 4'd3,
        REG_TYPE  = 4'd4,
        REG_IEN   = 4'd5,
        REG_STAT  = 4'd6,
        REG_OWN   = 4'd7,
        REG_PULL  = 4'd8
    } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    logic [W-1:0] stage1_q, stage2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= raw;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign lvl      = stage2_q;
    assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_prev,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] edge_mode,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] stat
);
    logic [W-1:0] hit;
    logic [W-1:0] stat_q;

    for (genvar g = 0; g < W; g++) begin : g_pin
        logic rise, fall, lvl_act;
        assign rise    = lvl[g] & ~lvl_prev[g];
        assign fall    = ~lvl[g] & lvl_prev[g];
        assign lvl_act = pol[g] ? lvl[g] : ~lvl[g];
        assign hit[g]  = edge_mode[g] ? (pol[g] ? rise : fall) : lvl_act;
    end

    // a trigger in the same clock as a clear keeps the bit set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | hit;
    end

    assign stat = stat_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr_en,
    input  logic [5:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic [PINS-1:0] pin_pullup,
    input  logic [PINS-1:0] alt_out,
    input  logic [PINS-1:0] alt_oe,
    output logic            irq
);
    localparam int MASK_LSB = 16;

    logic [3:0]      idx;
    logic [PINS-1:0] wr_mask, wr_val;
    logic [PINS-1:0] dir_q, dout_q, pol_q, type_q, ien_q, own_q, pull_q;
    logic [PINS-1:0] stat_q, lvl, lvl_prev, clr_mask;
    logic [PINS-1:0] rd_word;

    assign idx     = bus_addr[5:2];
    assign wr_mask = bus_wdata[MASK_LSB +: PINS];
    assign wr_val  = bus_wdata[PINS-1:0];

    function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old_v);
        return (old_v & ~wr_mask) | (wr_val & wr_mask);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            pol_q  <= '0;
            type_q <= '0;
            ien_q  <= '0;
            own_q  <= '1;
            pull_q <= '0;
        end else if (bus_wr_en) begin
            case (idx)
                REG_DIR:  dir_q  <= merge(dir_q);
                REG_DOUT: dout_q <= merge(dout_q);
                REG_POL:  pol_q  <= merge(pol_q);
                REG_TYPE: type_q <= merge(type_q);
                REG_IEN:  ien_q  <= merge(ien_q);
                REG_OWN:  own_q  <= merge(own_q);
                REG_PULL: pull_q <= merge(pull_q);
                default:  ;
            endcase
        end
    end

    assign clr_mask = (bus_wr_en && idx == REG_STAT) ? (wr_mask & ~wr_val) : '0;

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (pin_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    gpio_irq_detect #(.W(PINS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .lvl_prev  (lvl_prev),
        .pol       (pol_q),
        .edge_mode (type_q),
        .clr_mask  (clr_mask),
        .stat      (stat_q)
    );

    always_comb begin
        case (idx)
            REG_DIR:  rd_word = dir_q;
            REG_DOUT: rd_word = dout_q;
            REG_DIN:  rd_word = lvl;
            REG_POL:  rd_word = pol_q;
            REG_TYPE: rd_word = type_q;
            REG_IEN:  rd_word = ien_q;
            REG_STAT: rd_word = stat_q;
            REG_OWN:  rd_word = own_q;
            REG_PULL: rd_word = pull_q;
            default:  rd_word = '0;
        endcase
    end
    assign bus_rdata = 32'(rd_word);

    for (genvar g = 0; g < PINS; g++) begin : g_pad
        assign pin_out[g] = own_q[g] ? dout_q[g] : alt_out[g];
        assign pin_oe[g]  = own_q[g] ? dir_q[g]  : alt_oe[g];
    end

    assign pin_pullup = pull_q;
    assign irq        = |(stat_q & ien_q & ~dir_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int PINS = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr_en,
    input logic [5:0]      bus_addr,
    input logic [31:0]     bus_rdata,
    input logic            irq,
    input logic [PINS-1:0] stat_q,
    input logic [PINS-1:0] ien_q,
    input logic [PINS-1:0] dir_q,
    input logic [PINS-1:0] dout_q
);
    a_r6_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_q) & ~stat_q) != '0) |-> $past(bus_wr_en && bus_addr[5:2] == 4'd6))
        else $error("status bit fell without a status write");

    a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq)
        else $error("irq with all enables off");

    a_r8_quiet_all_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (&dir_q) |-> !irq)
        else $error("irq with every pin an output");

    a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en |=> ($stable(dout_q) && $stable(dir_q)))
        else $error("register changed without a write");

    a_r10_upper_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0)
        else $error("upper read half not zero");
endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .stat_q    (stat_q),
    .ien_q     (ien_q),
    .dir_q     (dir_q),
    .dout_q    (dout_q)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
    localparam int PINS = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr_en = 1'b0;
    logic [5:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out, pin_oe, pin_pullup;
    logic [PINS-1:0] alt_out = '0;
    logic [PINS-1:0] alt_oe = '0;
    logic            irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_bank #(.PINS(PINS)) u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
        .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
    );

    localparam logic [5:0] A_DIR = 6'h00, A_DOUT = 6'h04, A_DIN = 6'h08,
        A_POL = 6'h0C, A_TYPE = 6'h10, A_IEN = 6'h14, A_STAT = 6'h18,
        A_OWN = 6'h1C, A_PULL = 6'h20;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called just after a falling edge; the write lands on the next rising edge
    task automatic bw(input logic [5:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rchk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, $sformatf("read@%h", a), v, exp);
    endtask

    task automatic t_reset;
        rchk("R2", A_DIR, 0);   rchk("R2", A_DOUT, 0); rchk("R2", A_DIN, 0);
        rchk("R2", A_POL, 0);   rchk("R2", A_TYPE, 0); rchk("R2", A_IEN, 0);
        rchk("R2", A_STAT, 0);  rchk("R2", A_OWN, 32'h0000FFFF);
        rchk("R2", A_PULL, 0);
        chk("R2", "pin_oe", 32'(pin_oe), 0);
        chk("R2", "irq", 32'(irq), 0);
    endtask

    task automatic t_masked;
        bw(A_DOUT, 32'h00F0_00A5);
        rchk("R1", A_DOUT, 32'h00A0);
        chk("R1", "pin_out", 32'(pin_out), 32'h00A0);
        bw(A_DIR, 32'hFFFF_00F0);
        chk("R1", "pin_oe", 32'(pin_oe), 32'h00F0);
        bw(A_DOUT, 32'h0001_FFFF);
        chk("R1", "pin_out single", 32'(pin_out), 32'h00A1);
    endtask

    task automatic t_input;
        pin_in = 16'h1234;
        @(negedge clk);
        rchk("R3", A_DIN, 32'h0);
        @(negedge clk);
        rchk("R3", A_DIN, 32'h1234);
    endtask

    task automatic t_edge;
        bw(A_DIR, 32'hFFFF_0000);
        pin_in = '0;
        repeat (4) @(negedge clk);
        bw(A_TYPE, 32'hFFFF_FFFF);
        bw(A_POL, 32'hFFFF_FFFD);
        bw(A_STAT, 32'hFFFF_0000);
        rchk("R4", A_STAT, 0);
        pin_in = 16'h0003;
        repeat (2) @(negedge clk);
        rchk("R4", A_STAT, 0);
        @(negedge clk);
        rchk("R4", A_STAT, 32'h0001);
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        rchk("R4", A_STAT, 32'h0003);
        bw(A_STAT, 32'h0001_0000);
        rchk("R6", A_STAT, 32'h0002);
        bw(A_STAT, 32'h0002_0002);
        rchk("R6", A_STAT, 32'h0002);
    endtask

    task automatic t_irq;
        chk("R8", "irq disabled", 32'(irq), 0);
        bw(A_IEN, 32'h0002_0002);
        chk("R8", "irq enabled", 32'(irq), 1);
        bw(A_DIR, 32'h0002_0002);
        chk("R8", "irq pin output", 32'(irq), 0);
        bw(A_DIR, 32'h0002_0000);
        chk("R8", "irq pin input", 32'(irq), 1);
        bw(A_IEN, 32'h0002_0000);
        chk("R8", "irq masked", 32'(irq), 0);
        bw(A_STAT, 32'hFFFF_0000);
        rchk("R6", A_STAT, 0);
    endtask

    task automatic t_set_wins;
        pin_in = 16'h0001;
        repeat (2) @(negedge clk);
        bw(A_STAT, 32'h0001_0000);
        rchk("R7", A_STAT, 32'h0001);
        bw(A_STAT, 32'h0001_0000);
        rchk("R7", A_STAT, 0);
    endtask

    task automatic t_level;
        bw(A_TYPE, 32'h0004_0000);
        bw(A_POL, 32'h0004_0004);
        pin_in = 16'h0005;
        repeat (3) @(negedge clk);
        rchk("R5", A_STAT, 32'h0004);
        bw(A_STAT, 32'h0004_0000);
        rchk("R5", A_STAT, 32'h0004);
        pin_in = 16'h0001;
        repeat (3) @(negedge clk);
        rchk("R5", A_STAT, 32'h0004);
        bw(A_STAT, 32'h0004_0000);
        rchk("R5", A_STAT, 0);
    endtask

    task automatic t_alt;
        alt_out = '1;
        alt_oe  = '1;
        bw(A_OWN, 32'h0100_0000);
        chk("R9", "pin_out", 32'(pin_out), 32'h01A1);
        chk("R9", "pin_oe", 32'(pin_oe), 32'h0100);
        rchk("R9", A_OWN, 32'hFEFF);
        bw(A_OWN, 32'h0100_0100);
        chk("R9", "pin_out back", 32'(pin_out), 32'h00A1);
        chk("R9", "pin_oe back", 32'(pin_oe), 0);
    endtask

    task automatic t_ignore;
        bw(A_DIN, 32'hFFFF_FFFF);
        rchk("R10", A_DIN, 32'h0001);
        bw(6'h24, 32'hFFFF_FFFF);
        bw(6'h3C, 32'hFFFF_FFFF);
        rchk("R10", A_DOUT, 32'h00A1);
        rchk("R10", A_DIR, 0);
        rchk("R10", A_IEN, 0);
        rchk("R10", A_PULL, 0);
        rchk("R10", A_TYPE, 32'hFFFB);
        rchk("R10", 6'h24, 0);
        rchk("R10", 6'h3C, 0);
        rchk("R10", A_OWN, 32'h0000FFFF);
    endtask

    task automatic t_pull;
        bw(A_PULL, 32'h8001_8001);
        chk("R11", "pin_pullup", 32'(pin_pullup), 32'h8001);
        rchk("R11", A_PULL, 32'h8001);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_masked();
        t_input();
        t_edge();
        t_irq();
        t_set_wins();
        t_level();
        t_alt();
        t_ignore();
        t_pull();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule